// File: doc/BRIEF.md
# Bit-Sliced Add/Subtract Logic Unit

This block is a purely combinational arithmetic/logic unit of parameterised width. It is built as a ripple chain of identical one-bit slices. Each slice holds a full adder, an inverter on the second operand, and a four-way result selector. The carry out of each slice feeds the carry into the next, starting at bit 0 and ending at the top bit.

A single mode bit turns the adder into a subtractor. The bit inverts every bit of the second operand and also enters the chain as the carry into bit 0, so the chain computes `a + ~b + 1`. A 2-bit function code chooses what each slice passes out:

| Function code | Result |
|---|---|
| 0 | the adder output |
| 1 | the complement of the second operand |
| 2 | bitwise OR |
| 3 | bitwise AND |

Two flags come out beside the result. The first reports signed overflow of the adder. The second reports that the result is non-zero. A datapath uses the unit for address arithmetic, for comparisons through subtraction and the non-zero flag, and for simple logic.

Top module: `bsalu`

## Requirements
- R1: With function code 0 and the mode bit at 0, the result equals (A + B) mod 2^W.
- R2: With function code 0 and the mode bit at 1, the result equals (A - B) mod 2^W, computed as A + ~B + 1.
- R3: The overflow flag is 1 only when function code is 0 and the two's-complement result has the wrong sign. It is computed as the XOR of the carry into the top bit and the carry out of the top bit. For any function code other than 0 the flag is 0.
- R4: With function code 1 the result equals the bitwise complement of B, whatever the value of the mode bit.
- R5: With function code 2 the result equals A OR B, and the mode bit has no effect on it.
- R6: With function code 3 the result equals A AND B, and the mode bit has no effect on it.
- R7: The non-zero flag is 1 exactly when any bit of the result is 1, for every function code.
- R8: A carry produced at bit 0 ripples through all W slices. For example, all-ones plus 1 gives a result of 0 and a non-zero flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | first operand A |
| opb | input | W | second operand B |
| sub | input | 1 | mode bit: 0 add, 1 subtract |
| fsel | input | 2 | function code: 0 adder, 1 NOT B, 2 OR, 3 AND |
| res | output | W | result Q |
| ovf | output | 1 | signed overflow of the adder |
| nz | output | 1 | result is non-zero |

## Verification
The unit holds no state, so an internal fault shows at the ports in the same evaluation as the operands that excite it. A broken carry link shows only when a carry must cross that slice. For that reason the bench drives all-ones plus one, and the most negative and most positive values with a step of one. A wrong selector or mode wiring shows as a wrong result or a wrong flag for one function code. Each function code is therefore run with both values of the mode bit.

// File: rtl/bsalu.sv
module bsalu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  input  logic [1:0]   fsel,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         nz
);
  logic [W:0] cy;

  assign cy[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic bx, s;
    assign bx = opb[i] ^ sub;
    assign s = opa[i] ^ bx ^ cy[i];
    assign cy[i+1] = (opa[i] & bx) | (opa[i] & cy[i]) | (bx & cy[i]);
    always_comb begin
      unique case (fsel)
        2'd0: res[i] = s;
        2'd1: res[i] = ~opb[i];
        2'd2: res[i] = opa[i] | opb[i];
        default: res[i] = opa[i] & opb[i];
      endcase
    end
  end

  assign ovf = (fsel == 2'd0) & (cy[W] ^ cy[W-1]);
  assign nz  = |res;
endmodule

// File: rtl/bsalu_chk.sv
module bsalu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         sub,
  input logic [1:0]   fsel,
  input logic [W-1:0] res,
  input logic         ovf,
  input logic         nz
);
  logic [W-1:0] sum_ref, dif_ref;
  logic         sgn_ovf;

  assign sum_ref = opa + opb;
  assign dif_ref = opa - opb;
  assign sgn_ovf = sub ? ((opa[W-1] != opb[W-1]) && (dif_ref[W-1] != opa[W-1]))
                       : ((opa[W-1] == opb[W-1]) && (sum_ref[W-1] != opa[W-1]));

  always_comb begin
    if (fsel == 2'd0 && !sub) p_sum_r1: assert (res == sum_ref);
    if (fsel == 2'd0 && sub)  p_diff_r2: assert (res == dif_ref);
    if (fsel != 2'd0)         p_no_overflow_r3: assert (!ovf);
    if (fsel == 2'd0)         p_overflow_r3: assert (ovf == sgn_ovf);
    if (fsel == 2'd1)         p_not_r4: assert (res == ~opb);
    if (fsel == 2'd2)         p_or_r5: assert (res == (opa | opb));
    if (fsel == 2'd3)         p_and_r6: assert (res == (opa & opb));
    if (fsel == 2'd2)         p_nonzero_r7: assert (nz == ((opa | opb) != '0));
  end
endmodule

bind bsalu bsalu_chk #(.W(W)) u_chk (.*);

// File: tb/test_bsalu.sv
module test_bsalu;
  localparam int W = 32;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAXN = {1'b1, {(W-1){1'b0}}};

  logic clk = 0;
  logic rst = 1;
  logic [W-1:0] opa, opb, res;
  logic sub, ovf, nz;
  logic [1:0] fsel;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bsalu #(.W(W)) i_bsalu (.opa(opa), .opb(opb), .sub(sub), .fsel(fsel),
                          .res(res), .ovf(ovf), .nz(nz));

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic s, logic [1:0] f);
    @(negedge clk);
    opa = a; opb = b; sub = s; fsel = f;
    @(posedge clk);
    #1;
  endtask

  task automatic run_check(logic [W-1:0] a, logic [W-1:0] b, logic s, logic [1:0] f);
    logic [W-1:0] q;
    logic v;
    apply(a, b, s, f);
    case (f)
      2'd0: q = s ? a - b : a + b;
      2'd1: q = ~b;
      2'd2: q = a | b;
      default: q = a & b;
    endcase
    v = 1'b0;
    if (f == 2'd0)
      v = s ? ((a[W-1] != b[W-1]) && (q[W-1] != a[W-1]))
            : ((a[W-1] == b[W-1]) && (q[W-1] != a[W-1]));
    case (f)
      2'd0: chk(s ? "R2 diff" : "R1 sum", res, q);
      2'd1: chk("R4 notb", res, q);
      2'd2: chk("R5 or", res, q);
      default: chk("R6 and", res, q);
    endcase
    chk("R3 ovf", W'(ovf), W'(v));
    chk("R7 nz", W'(nz), W'(q != '0));
  endtask

  task automatic t_reset;
    apply('0, '0, 1'b0, 2'd0);
    chk("R1 reset res", res, '0);
    chk("R7 reset nz", W'(nz), '0);
    chk("R3 reset ovf", W'(ovf), '0);
  endtask

  task automatic t_add;
    run_check(32'd5, 32'd7, 0, 0);
    run_check(32'h1234_5678, 32'h0FED_CBA9, 0, 0);
    run_check(MAXP, 32'd1, 0, 0);
    chk("R3 maxp+1 ovf", W'(ovf), 1);
    run_check(MAXN, MAXN, 0, 0);
    chk("R3 maxn+maxn ovf", W'(ovf), 1);
  endtask

  task automatic t_sub;
    run_check(32'd9, 32'd4, 1, 0);
    run_check(32'd4, 32'd9, 1, 0);
    run_check(MAXN, 32'd1, 1, 0);
    chk("R3 maxn-1 ovf", W'(ovf), 1);
    chk("R2 maxn-1 res", res, MAXP);
    run_check(32'hCAFE_0001, 32'hCAFE_0001, 1, 0);
    chk("R7 equal nz", W'(nz), 0);
  endtask

  task automatic t_ripple_r8;
    run_check('1, 32'd1, 0, 0);
    chk("R8 ripple res", res, '0);
    chk("R8 ripple nz", W'(nz), 0);
    chk("R8 ripple ovf", W'(ovf), 0);
  endtask

  task automatic t_logic;
    for (int s = 0; s < 2; s++) begin
      run_check(32'hF0F0_1234, 32'h0FF0_8001, s[0], 1);
      run_check(MAXP, MAXN, s[0], 2);
      chk("R3 or forced ovf", W'(ovf), 0);
      run_check(32'hAAAA_5555, 32'h5555_AAAA, s[0], 3);
      chk("R6 disjoint and nz", W'(nz), 0);
      run_check(32'h0, '1, s[0], 1);
      chk("R4 not ones", res, '0);
    end
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++)
      run_check($urandom, $urandom, 1'($urandom), 2'($urandom));
  endtask

  initial begin
    opa = '0; opb = '0; sub = 0; fsel = 0;
    repeat (2) @(posedge clk);
    rst = 0;
    t_reset;
    t_add;
    t_sub;
    t_ripple_r8;
    t_logic;
    t_random;
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule